// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the register slave of a simple serial port. A CPU reaches it through a word-addressed bus with a combinational read path. The block passes each byte the CPU writes for transmission to an outgoing byte stream. It collects bytes from an incoming byte stream into a small receive FIFO. Both streams use valid/ready handshakes. Line framing, bit timing and DMA belong to other blocks; the transmit-DMA and transmit-control words are plain storage here.

The FIFO contents are visible through a status/data word at two addresses. One address only looks at the oldest byte. The other address also removes that byte. A raw interrupt register collects a transmit-done pair and a receive-pending flag. A mask selects which raw bits reach the single level-sensitive interrupt line. A write-one-to-clear acknowledge word clears raw bits. After a transmit, the first acknowledge spares bit 0.

Top module: `serport_regs`

## Requirements
- R1: Byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x28, 0x2C and 0x30 read back the value last stored there. Writes to 0x20, 0x24, 0x34 and 0x38 change nothing. Reads at or above 0x3C return 0 and writes there are ignored. Address bits 1:0 are ignored.
- R2: A read of 0x20 or 0x24 returns the following. Bits 7:0 hold the oldest FIFO byte, or 0 when the FIFO is empty. Bit 16 is 1 when the FIFO holds data. Bits 22 and 24 are always 1. All other bits are 0.
- R3: A read of 0x20 removes the oldest byte when the FIFO is not empty. A read of 0x24 never changes the FIFO.
- R4: The FIFO holds 16 bytes and returns them in arrival order. A byte offered while the FIFO is full (as seen before the clock edge) is accepted on the handshake and discarded.
- R5: `rx_ready` equals bit 3 of the receive control word (offset 0x08). No byte enters the FIFO while that bit is 0.
- R6: After reset, the receive control word reads 0x0001_0000, every other stored word and the raw interrupt word read 0, and `tx_valid`, `rx_ready` and `irq` are low.
- R7: A write to 0x1C stores the value and loads its low byte onto `tx_data` with `tx_valid` high. The byte is held until a cycle with `tx_ready` high. The write also sets raw interrupt bits 0 and 1 and a pending-transmit flag.
- R8: A write to 0x30 clears each raw bit written as 1. If the pending flag is set, bit 0 is removed from the written value and the flag clears. The value actually applied is what 0x30 reads back.
- R9: Raw interrupt bit 3 (read at 0x34) is 1 exactly when the FIFO is not empty.
- R10: Offset 0x38 reads raw AND mask, with the mask at 0x2C. `irq` is high exactly when that word is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_ready | input | 1 | Sink takes the outgoing byte |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Receiver enabled |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default depth of 16 and an address width of 6. At these values, 17 pushes reach the full-FIFO drop, and steady traffic wraps the pointers many times. The 6-bit address also covers the word at 0x3C, so out-of-window accesses are exercised. A random phase mixes pops with pushes into a full FIFO and acknowledges with transmits. This reaches the same-cycle pop-and-push and the pending-flag corner under many interleavings.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int WORD_W      = 32;
  localparam int N_WORDS     = 15;
  // word indices (byte offset / 4)
  localparam int W_TXCTL     = 0;
  localparam int W_TXDMA     = 1;
  localparam int W_RXCTL     = 2;
  localparam int W_DOUT      = 7;
  localparam int W_STAT_POP  = 8;
  localparam int W_STAT_PEEK = 9;
  localparam int W_IMASK     = 11;
  localparam int W_IACK      = 12;
  localparam int W_IRAW      = 13;
  localparam int W_IMSK      = 14;
  // status and control bit positions
  localparam int STB_DAV     = 16;
  localparam int STB_IDLE    = 22;
  localparam int STB_RDY     = 24;
  localparam int RXEN_BIT    = 3;
  localparam int RXIRQ_BIT   = 3;
  localparam logic [WORD_W-1:0] RXCTL_RST = 32'h0001_0000;
endpackage

// File: rtl/serport_rxfifo.sv
module serport_rxfifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    wdata,
  input  logic             pop,
  output logic [DW-1:0]    rdata,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wptr_d = push ? bump(wptr_q) : wptr_q;
    rptr_d = pop  ? bump(rptr_q) : rptr_q;
    cnt_d  = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + CNT_W'(1);
    else if (pop && !push) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wdata;
  end

  assign count = cnt_q;
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign rdata = empty ? '0 : mem[rptr_q];
endmodule

// File: rtl/serport_regbank.sv
module serport_regbank
  import serport_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_val,
  output logic [WORD_W-1:0] words [N_WORDS]
);
  for (genvar i = 0; i < N_WORDS; i++) begin : g_w
    if (i == W_STAT_POP || i == W_STAT_PEEK || i == W_IRAW || i == W_IMSK) begin : g_ro
      assign words[i] = '0;
    end else begin : g_rw
      logic [WORD_W-1:0] q, d;
      logic              we;
      assign we = wr_en && (wr_idx == IDX_W'(i));
      always_comb d = we ? wr_val : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= (i == W_RXCTL) ? RXCTL_RST : '0;
        else        q <= d;
      end
      assign words[i] = q;
    end
  end
endmodule

// File: rtl/serport_irqctl.sv
module serport_irqctl
  import serport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr,
  input  logic              ack_wr,
  input  logic [WORD_W-1:0] ack_val,
  input  logic              rx_nonempty,
  input  logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] ack_applied,
  output logic [WORD_W-1:0] raw,
  output logic [WORD_W-1:0] masked,
  output logic              irq
);
  logic [WORD_W-1:0] raw_q, raw_d;
  logic              pend_q, pend_d;

  always_comb begin
    ack_applied = ack_val;
    if (pend_q) ack_applied[0] = 1'b0;
    raw_d  = raw_q;
    pend_d = pend_q;
    if (tx_wr) begin
      raw_d  = raw_q | WORD_W'(3);
      pend_d = 1'b1;
    end else if (ack_wr) begin
      raw_d  = raw_q & ~ack_applied;
      pend_d = 1'b0;
    end
    raw_d[RXIRQ_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    raw            = raw_q;
    raw[RXIRQ_BIT] = rx_nonempty;
  end
  assign masked = raw & mask;
  assign irq    = |masked;
endmodule

// File: rtl/serport_regs.sv
module serport_regs
  import serport_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 6,
  localparam int IDX_W = ADDR_W - 2,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              irq
);
  logic [IDX_W-1:0]  acc_word;
  logic              in_win, wr_acc, rd_acc;
  logic              dout_wr, ack_wr, pop_rd;
  logic [WORD_W-1:0] words [N_WORDS];
  logic [WORD_W-1:0] store_val, ack_applied, raw_w, masked_w, mask_word, status_w;
  logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [7:0]        fifo_head;
  logic [CNT_W-1:0]  fifo_count;
  logic [7:0]        txd_q, txd_d;
  logic              txv_q, txv_d;
  logic              unused_addr_lsb;

  assign unused_addr_lsb = ^bus_addr[1:0];
  assign acc_word = bus_addr[ADDR_W-1:2];
  assign in_win   = (acc_word < IDX_W'(N_WORDS));
  assign wr_acc   = bus_en && bus_we && in_win;
  assign rd_acc   = bus_en && !bus_we && in_win;
  assign dout_wr  = wr_acc && (acc_word == IDX_W'(W_DOUT));
  assign ack_wr   = wr_acc && (acc_word == IDX_W'(W_IACK));
  assign pop_rd   = rd_acc && (acc_word == IDX_W'(W_STAT_POP));

  assign store_val = ack_wr ? ack_applied : bus_wdata;

  serport_regbank #(.IDX_W(IDX_W)) i_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_acc),
    .wr_idx (acc_word),
    .wr_val (store_val),
    .words  (words)
  );

  assign mask_word = words[W_IMASK];
  assign rx_ready  = words[W_RXCTL][RXEN_BIT];
  assign fifo_push = rx_valid && rx_ready && !fifo_full;
  assign fifo_pop  = pop_rd && !fifo_empty;

  serport_rxfifo #(.DEPTH(DEPTH), .DW(8)) i_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .wdata (rx_data),
    .pop   (fifo_pop),
    .rdata (fifo_head),
    .count (fifo_count),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  serport_irqctl i_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_wr       (dout_wr),
    .ack_wr      (ack_wr),
    .ack_val     (bus_wdata),
    .rx_nonempty (!fifo_empty),
    .mask        (mask_word),
    .ack_applied (ack_applied),
    .raw         (raw_w),
    .masked      (masked_w),
    .irq         (irq)
  );

  // transmit byte holding stage
  always_comb begin
    txv_d = txv_q;
    txd_d = txd_q;
    if (dout_wr) begin
      txv_d = 1'b1;
      txd_d = bus_wdata[7:0];
    end else if (txv_q && tx_ready) begin
      txv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txv_q <= 1'b0;
      txd_q <= '0;
    end else begin
      txv_q <= txv_d;
      txd_q <= txd_d;
    end
  end

  assign tx_valid = txv_q;
  assign tx_data  = txd_q;

  always_comb begin
    status_w           = '0;
    status_w[7:0]      = fifo_head;
    status_w[STB_DAV]  = !fifo_empty;
    status_w[STB_IDLE] = 1'b1;
    status_w[STB_RDY]  = 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    if (in_win) begin
      if (acc_word == IDX_W'(W_STAT_POP) || acc_word == IDX_W'(W_STAT_PEEK))
        bus_rdata = status_w;
      else if (acc_word == IDX_W'(W_IRAW))
        bus_rdata = raw_w;
      else if (acc_word == IDX_W'(W_IMSK))
        bus_rdata = masked_w;
      else
        bus_rdata = words[acc_word];
    end
  end
endmodule

// File: rtl/serport_regs_chk.sv
module serport_regs_chk
  import serport_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 6,
  localparam int IDX_W = ADDR_W - 2,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [IDX_W-1:0]  acc_word,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              irq,
  input logic [WORD_W-1:0] mask_word,
  input logic [CNT_W-1:0]  fifo_count
);
  logic rd_pop, rd_peek, wr_dout, offer;
  assign rd_pop  = bus_en && !bus_we && acc_word == IDX_W'(W_STAT_POP);
  assign rd_peek = bus_en && !bus_we && acc_word == IDX_W'(W_STAT_PEEK);
  assign wr_dout = bus_en && bus_we && acc_word == IDX_W'(W_DOUT);
  assign offer   = rx_valid && rx_ready;

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));
  a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    offer && fifo_count == CNT_W'(DEPTH) && !rd_pop |=> fifo_count == CNT_W'(DEPTH));
  a_r3_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    rd_peek && !offer |=> $stable(fifo_count));
  a_r3_pop_takes: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop && fifo_count != '0 && !offer |=> fifo_count == $past(fifo_count) - CNT_W'(1));
  a_r5_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready && !rd_pop |=> $stable(fifo_count));
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !wr_dout |=> tx_valid && $stable(tx_data));
  a_r10_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
    mask_word == '0 |-> !irq);
endmodule

bind serport_regs serport_regs_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .acc_word   (acc_word),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .irq        (irq),
  .mask_word  (mask_word),
  .fifo_count (fifo_count)
);

// File: tb/test_serport_regs.sv
module test_serport_regs;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  tx_data, rx_data;
  logic        tx_valid, tx_ready, rx_valid, rx_ready, irq;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // reference model state
  logic [31:0] m_regs [15];
  logic [7:0]  m_q [$];
  logic [31:0] m_raw;
  bit          m_pend, m_txv;
  logic [7:0]  m_txd;
  logic [31:0] last_rd;

  always #2 clk = ~clk;

  serport_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_serport_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_rawfull();
    logic [31:0] r = m_raw;
    r[3] = (m_q.size() != 0);
    return r;
  endfunction

  function automatic logic [31:0] m_read(input int w);
    logic [31:0] r = 32'h0;
    if (w == 8 || w == 9) begin
      r = 32'h0140_0000;
      if (m_q.size() != 0) r = r | 32'h0001_0000 | {24'h0, m_q[0]};
    end else if (w == 13) r = m_rawfull();
    else if (w == 14) r = m_rawfull() & m_regs[11];
    else if (w < 15) r = m_regs[w];
    return r;
  endfunction

  function automatic string rd_tag(input int w);
    if (w == 8 || w == 9) return "R2";
    if (w == 13) return "R9";
    if (w == 14) return "R10";
    return "R1";
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 15; i++) m_regs[i] = 32'h0;
    m_regs[2] = 32'h0001_0000;
    m_q.delete();
    m_raw = 0; m_pend = 0; m_txv = 0; m_txd = 0;
  endtask

  task automatic m_compare();
    int w = int'(bus_addr[5:2]);
    chk("R5 rx_ready", {31'h0, rx_ready}, {31'h0, m_regs[2][3]});
    chk("R7 tx_valid", {31'h0, tx_valid}, {31'h0, m_txv});
    if (m_txv) chk("R7 tx_data", {24'h0, tx_data}, {24'h0, m_txd});
    chk("R10 irq", {31'h0, irq}, {31'h0, |(m_rawfull() & m_regs[11])});
    if (bus_en && !bus_we) chk(rd_tag(w), bus_rdata, m_read(w));
    last_rd = bus_rdata;
  endtask

  task automatic m_update();
    int w = int'(bus_addr[5:2]);
    bit full = (m_q.size() >= DEPTH);
    logic [31:0] v;
    if (bus_en && !bus_we && w == 8 && m_q.size() != 0) void'(m_q.pop_front());
    if (rx_valid && m_regs[2][3] && !full) m_q.push_back(rx_data);
    if (bus_en && bus_we && w == 7) begin
      m_txv = 1; m_txd = bus_wdata[7:0];
    end else if (m_txv && tx_ready) m_txv = 0;
    if (bus_en && bus_we && w < 15) begin
      case (w)
        7: begin m_regs[7] = bus_wdata; m_raw = m_raw | 32'h3; m_pend = 1; end
        12: begin
          v = bus_wdata;
          if (m_pend) begin v[0] = 1'b0; m_pend = 0; end
          m_regs[12] = v;
          m_raw = m_raw & ~v;
        end
        8, 9, 13, 14: ;
        default: m_regs[w] = bus_wdata;
      endcase
    end
  endtask

  task automatic step(input bit en, input bit we, input logic [5:0] a, input logic [31:0] wd,
                      input bit rv, input logic [7:0] rd, input bit tr);
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd;
    rx_valid = rv; rx_data = rd; tx_ready = tr;
    #1;
    m_compare();
    @(posedge clk);
    m_update();
  endtask

  task automatic idle();
    step(0, 0, 6'h0, 0, 0, 0, 0);
  endtask
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    step(1, 1, a, d, 0, 0, 0);
  endtask
  task automatic rd(input logic [5:0] a);
    step(1, 0, a, 0, 0, 0, 0);
  endtask
  task automatic push(input logic [7:0] b);
    step(0, 0, 6'h0, 0, 1, b, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rx_valid = 0; rx_data = 0; tx_ready = 0;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 reset tx_valid", {31'h0, tx_valid}, 32'h0);
    chk("R6 reset rx_ready", {31'h0, rx_ready}, 32'h0);
    chk("R6 reset irq", {31'h0, irq}, 32'h0);
    rst_n = 1;
    idle();
    rd(6'h08); chk("R6 rxctl reset", last_rd, 32'h0001_0000);
    rd(6'h34); chk("R6 raw reset", last_rd, 32'h0);
    rd(6'h2C); chk("R6 mask reset", last_rd, 32'h0);

    // enable receiver, peek versus pop
    wr(6'h08, 32'h0001_0008);
    push(8'h11); push(8'h22); push(8'h33);
    rd(6'h24); chk("R2 peek format", last_rd, 32'h0141_0011);
    rd(6'h24); chk("R3 peek keeps", last_rd, 32'h0141_0011);
    rd(6'h20); chk("R3 pop returns", last_rd, 32'h0141_0011);
    rd(6'h24); chk("R3 pop advanced", last_rd, 32'h0141_0022);
    rd(6'h34); chk("R9 raw rx bit", last_rd, 32'h8);

    // mask the receive interrupt
    wr(6'h2C, 32'h8);
    idle(); chk("R10 irq on", {31'h0, irq}, 32'h1);
    rd(6'h38); chk("R10 masked", last_rd, 32'h8);
    rd(6'h20); rd(6'h20);
    rd(6'h24); chk("R2 empty format", last_rd, 32'h0140_0000);
    rd(6'h34); chk("R9 raw cleared", last_rd, 32'h0);
    idle(); chk("R10 irq off", {31'h0, irq}, 32'h0);

    // fill past capacity
    for (int i = 0; i < 17; i++) push(8'h40 + 8'(i));
    for (int i = 0; i < 16; i++) begin
      rd(6'h20); chk("R4 order", {24'h0, last_rd[7:0]}, 32'h40 + i);
    end
    rd(6'h24); chk("R4 extra dropped", last_rd, 32'h0140_0000);

    // receiver disabled
    wr(6'h08, 32'h0001_0000);
    push(8'h99);
    rd(6'h24); chk("R5 closed", last_rd, 32'h0140_0000);

    // transmit path and acknowledge
    wr(6'h1C, 32'h0000_01A5);
    idle(); chk("R7 tx byte", {23'h0, tx_valid, tx_data}, 32'h1A5);
    rd(6'h34); chk("R7 raw set", last_rd, 32'h3);
    rd(6'h1C); chk("R1 dout stored", last_rd, 32'h1A5);
    wr(6'h30, 32'h3);
    rd(6'h34); chk("R8 first ack keeps bit0", last_rd, 32'h1);
    rd(6'h30); chk("R8 ack readback", last_rd, 32'h2);
    wr(6'h30, 32'h1);
    rd(6'h34); chk("R8 second ack clears", last_rd, 32'h0);
    step(0, 0, 6'h0, 0, 0, 0, 1);
    idle(); chk("R7 tx taken", {31'h0, tx_valid}, 32'h0);

    // read-only, plain and out-of-window words
    wr(6'h34, 32'hFFFF_FFFF); wr(6'h38, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF); wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h34); chk("R1 raw write ignored", last_rd, 32'h0);
    rd(6'h24); chk("R1 status write ignored", last_rd, 32'h0140_0000);
    wr(6'h0D, 32'hDEAD_BEEF);
    rd(6'h0C); chk("R1 plain word", last_rd, 32'hDEAD_BEEF);
    wr(6'h3C, 32'h1234_5678);
    rd(6'h3C); chk("R1 outside window", last_rd, 32'h0);

    // random traffic against the model
    wr(6'h08, 32'h0001_0008);
    for (int n = 0; n < 4000; n++) begin
      int unsigned r = $urandom;
      logic [5:0]  a = 6'(r[5:0]);
      logic [31:0] d = $urandom;
      if (a[5:2] == 4'h2) d[3] = (r[20:18] != 0);
      step(r[6], r[7], a, d, r[8] | r[9], 8'(r[17:10]), r[21]);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule